// File: doc/BRIEF.md
# Pipeline Stall and Flush Controller

This block is the hazard control logic for an in-order five-stage integer pipeline (fetch, decode, execute, memory, write-back). It watches the instruction in decode and the instruction one stage ahead in execute. When a load in execute writes a register that the decoding instruction actually reads, the block freezes the fetch side for one cycle and pushes a bubble into execute. The loaded value then reaches the dependent instruction through the forwarding path, which lies outside this block.

Branches are predicted not taken. Branch conditions and jumps resolve in the memory stage. When the memory stage reports a taken branch or any jump, the block clears the three younger pipeline registers and steers the PC to the target. A flush always takes priority over a stall that the block detects in the same cycle. Every output is combinational from the present inputs, so the surrounding pipeline registers act on the controls at the next clock edge.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: When a stall is raised, pc_hold, ifid_hold and idex_clear are 1, and pc_redirect, ifid_clear and exmem_clear are 0.
- R2: A load in execute whose destination equals the decode rs stalls the pipeline unless the decode opcode is 0x02 or 0x03 (jumps, which read no register).
- R3: A load in execute whose destination equals the decode rt stalls the pipeline only for opcodes 0x00 (register ALU), 0x2B (store word) and 0x04 (branch-if-equal). Opcode 0x23 (load word) and immediate ALU opcodes such as 0x08 do not stall on an rt match.
- R4: A load whose destination is register 0 never causes a stall.
- R5: With no load in execute, or with no operand match, every control output is 0.
- R6: When mem_br_taken or mem_jump is 1, pc_redirect, ifid_clear, idex_clear and exmem_clear are 1, and pc_hold and ifid_hold are 0.
- R7: A flush overrides a stall detected in the same cycle. The output is the R6 pattern.
- R8: While rst_n is 0, every control output is 0.
- R9: Inside a pipeline, a load followed at once by a dependent instruction delays that instruction's write-back by exactly one cycle.
- R10: Inside a pipeline, a taken branch lets the target reach write-back four cycles after the branch. This is a three-cycle penalty. The three instructions that follow the branch never reach write-back.
- R11: Inside a pipeline, a stream with no load-use dependency retires one instruction per cycle, with no bubble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| id_opcode | input | 6 | Opcode of the instruction held in IF/ID |
| id_rs | input | 5 | First source register of the IF/ID instruction |
| id_rt | input | 5 | Second source register of the IF/ID instruction |
| ex_is_load | input | 1 | The ID/EX instruction is a load |
| ex_load_dst | input | 5 | Destination register of the ID/EX load |
| mem_br_taken | input | 1 | The MEM instruction is a branch whose condition holds |
| mem_jump | input | 1 | The MEM instruction is a jump |
| pc_hold | output | 1 | Keep the PC unchanged |
| pc_redirect | output | 1 | Load the PC with the branch or jump target |
| ifid_hold | output | 1 | Keep the IF/ID contents |
| ifid_clear | output | 1 | Zero IF/ID |
| idex_clear | output | 1 | Zero ID/EX, which inserts a bubble |
| exmem_clear | output | 1 | Zero EX/MEM |

## Verification
The assertions assume a pipeline in which mem_br_taken and mem_jump describe a single valid instruction. They also assume that a cleared register reads as a register-ALU no-op with zero specifiers, so a cleared ID/EX never presents a load. The stimulus keeps within these assumptions in two ways. Directed vectors apply one consistent set of stage contents per cycle. A behavioural model of four pipeline registers derives every input from the instructions it holds and applies the block's hold and clear controls exactly as a real pipeline would.

// File: rtl/hz_pkg.sv
// Shared constants and types for the stall/flush controller.
// Assumes a 6-bit major opcode and a 32-entry register file.
package hz_pkg;
    localparam int OPC_W  = 6;
    localparam int RIDX_W = 5;

    localparam logic [OPC_W-1:0] OPC_RTYPE = 6'h00;
    localparam logic [OPC_W-1:0] OPC_JUMP  = 6'h02;
    localparam logic [OPC_W-1:0] OPC_JAL   = 6'h03;
    localparam logic [OPC_W-1:0] OPC_BEQ   = 6'h04;
    localparam logic [OPC_W-1:0] OPC_LOAD  = 6'h23;
    localparam logic [OPC_W-1:0] OPC_STORE = 6'h2B;

    // Control bundle driven to the pipeline registers
    typedef struct packed {
        logic pc_hold;
        logic pc_redirect;
        logic ifid_hold;
        logic ifid_clear;
        logic idex_clear;
        logic exmem_clear;
    } hz_ctl_t;
endpackage

// File: rtl/hz_operand_use.sv
// Decodes which source specifiers the decode-stage instruction really reads.
// Assumes: jumps read nothing, loads and immediate ALU ops read only rs,
// register ALU ops, stores and equality branches read both rs and rt.
module hz_operand_use #(
    parameter int OP_W = hz_pkg::OPC_W
) (
    input  logic [OP_W-1:0] opcode,
    output logic            reads_rs,
    output logic            reads_rt
);
    import hz_pkg::*;

    // Map the opcode onto the two operand-read flags
    always_comb begin
        reads_rs = 1'b1;
        reads_rt = 1'b0;
        case (opcode)
            OPC_RTYPE, OPC_STORE, OPC_BEQ: reads_rt = 1'b1;
            OPC_JUMP, OPC_JAL:             reads_rs = 1'b0;
            default:                       reads_rt = 1'b0;
        endcase
    end
endmodule

// File: rtl/hz_loaduse_detect.sv
// Flags a load-use dependency between the ID/EX load and the IF/ID reader.
// Assumes the load destination is valid only while ld_valid is high;
// register 0 is hard-wired and never creates a dependency.
module hz_loaduse_detect #(
    parameter int RW   = hz_pkg::RIDX_W,
    parameter int NSRC = 2
) (
    input  logic [NSRC-1:0][RW-1:0] src_idx,
    input  logic [NSRC-1:0]         src_used,
    input  logic                    ld_valid,
    input  logic [RW-1:0]           ld_dst,
    output logic                    stall
);
    logic [NSRC-1:0] hit;

    // One comparator per source operand
    for (genvar g = 0; g < NSRC; g++) begin : g_cmp
        assign hit[g] = src_used[g] && (src_idx[g] == ld_dst);
    end

    // Combine hits, masking the zero register
    assign stall = ld_valid && (ld_dst != '0) && (|hit);
endmodule

// File: rtl/hz_ctrl_arbiter.sv
// Turns stall and flush requests into hold/clear controls.
// Flush has priority; reset forces every control inactive.
module hz_ctrl_arbiter (
    input  logic            rst_n,
    input  logic            stall,
    input  logic            flush,
    output hz_pkg::hz_ctl_t ctl
);
    // Priority selection: reset, then flush, then stall
    always_comb begin
        ctl = '0;
        if (!rst_n) begin
            ctl = '0;
        end else if (flush) begin
            ctl.pc_redirect = 1'b1;
            ctl.ifid_clear  = 1'b1;
            ctl.idex_clear  = 1'b1;
            ctl.exmem_clear = 1'b1;
        end else if (stall) begin
            ctl.pc_hold    = 1'b1;
            ctl.ifid_hold  = 1'b1;
            ctl.idex_clear = 1'b1;
        end
    end
endmodule

// File: rtl/pipe_hazard_ctrl.sv
// Hazard controller for a five-stage pipeline: one-cycle load-use stall
// detected in decode, and a three-register flush for branches and jumps
// resolved in MEM (assume not taken). Outputs are combinational and are
// consumed by the pipeline registers at the next clock edge.
module pipe_hazard_ctrl #(
    parameter int OP_W = hz_pkg::OPC_W,
    parameter int RW   = hz_pkg::RIDX_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OP_W-1:0] id_opcode,
    input  logic [RW-1:0]   id_rs,
    input  logic [RW-1:0]   id_rt,
    input  logic            ex_is_load,
    input  logic [RW-1:0]   ex_load_dst,
    input  logic            mem_br_taken,
    input  logic            mem_jump,
    output logic            pc_hold,
    output logic            pc_redirect,
    output logic            ifid_hold,
    output logic            ifid_clear,
    output logic            idex_clear,
    output logic            exmem_clear
);
    localparam int NSRC = 2;

    logic                    use_rs, use_rt;
    logic [NSRC-1:0][RW-1:0] src_idx;
    logic [NSRC-1:0]         src_used;
    logic                    stall_req, flush_req;
    hz_pkg::hz_ctl_t         ctl;

    hz_operand_use #(.OP_W(OP_W)) u_use (
        .opcode   (id_opcode),
        .reads_rs (use_rs),
        .reads_rt (use_rt)
    );

    // Pack source operands in a fixed order: index 0 is rs, index 1 is rt
    assign src_idx  = {id_rt, id_rs};
    assign src_used = {use_rt, use_rs};

    hz_loaduse_detect #(.RW(RW), .NSRC(NSRC)) u_det (
        .src_idx  (src_idx),
        .src_used (src_used),
        .ld_valid (ex_is_load),
        .ld_dst   (ex_load_dst),
        .stall    (stall_req)
    );

    // A taken branch or any jump in MEM flushes the younger stages
    assign flush_req = mem_br_taken | mem_jump;

    hz_ctrl_arbiter u_arb (
        .rst_n (rst_n),
        .stall (stall_req),
        .flush (flush_req),
        .ctl   (ctl)
    );

    assign pc_hold     = ctl.pc_hold;
    assign pc_redirect = ctl.pc_redirect;
    assign ifid_hold   = ctl.ifid_hold;
    assign ifid_clear  = ctl.ifid_clear;
    assign idex_clear  = ctl.idex_clear;
    assign exmem_clear = ctl.exmem_clear;

    AST_STALL_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        pc_hold |-> (ifid_hold && idex_clear && !exmem_clear && !ifid_clear)); // R1
    AST_ZERO_DST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_load_dst == '0 && !mem_br_taken && !mem_jump) |-> !pc_hold); // R4
    AST_NO_LOAD_NO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_is_load |-> (!pc_hold && !ifid_hold)); // R5
    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_br_taken || mem_jump) |-> (pc_redirect && ifid_clear && idex_clear && exmem_clear)); // R6
    AST_FLUSH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_br_taken || mem_jump) |-> (!pc_hold && !ifid_hold)); // R7
    AST_JUMP_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (id_opcode == hz_pkg::OPC_JUMP && !mem_br_taken && !mem_jump) |-> !ifid_hold); // R2
endmodule

// File: tb/pipe_hazard_ctrl_bench.sv
`timescale 1ns/1ps
module pipe_hazard_ctrl_bench;
    localparam real TCK = 8.0;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] id_opcode = '0;
    logic [4:0] id_rs = '0, id_rt = '0, ex_load_dst = '0;
    logic       ex_is_load = 1'b0, mem_br_taken = 1'b0, mem_jump = 1'b0;
    logic       pc_hold, pc_redirect, ifid_hold, ifid_clear, idex_clear, exmem_clear;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #(TCK/2) clk = ~clk;

    pipe_hazard_ctrl u_pipe_hazard_ctrl (
        .clk, .rst_n, .id_opcode, .id_rs, .id_rt, .ex_is_load, .ex_load_dst,
        .mem_br_taken, .mem_jump, .pc_hold, .pc_redirect, .ifid_hold,
        .ifid_clear, .idex_clear, .exmem_clear
    );

    // Expected bundle order: pc_hold, pc_redirect, ifid_hold, ifid_clear, idex_clear, exmem_clear
    localparam logic [5:0] E_NONE  = 6'b000000;
    localparam logic [5:0] E_STALL = 6'b101010;
    localparam logic [5:0] E_FLUSH = 6'b010111;

    typedef struct { logic [5:0] exp; string tag; } sb_item_t;
    sb_item_t sb_q[$];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Driver: apply one vector after a rising edge and queue its expectation
    task automatic drive(input logic [5:0] op, input logic [4:0] rs, input logic [4:0] rt,
                         input logic ld, input logic [4:0] dst, input logic bt,
                         input logic jp, input logic [5:0] exp, input string tag);
        sb_item_t it;
        @(posedge clk); #2;
        id_opcode = op; id_rs = rs; id_rt = rt; ex_is_load = ld;
        ex_load_dst = dst; mem_br_taken = bt; mem_jump = jp;
        it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: compare outputs at the falling edge against the queued item
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                sb_item_t it;
                logic [5:0] act;
                it  = sb_q.pop_front();
                act = {pc_hold, pc_redirect, ifid_hold, ifid_clear, idex_clear, exmem_clear};
                check(act === it.exp, it.tag, int'(act), int'(it.exp));
            end
        end
    end

    // ---------------- behavioural pipeline model ----------------
    localparam int PMAX = 16;
    logic [5:0] p_op  [PMAX];
    logic [4:0] p_rs  [PMAX];
    logic [4:0] p_rt  [PMAX];
    bit         p_tk  [PMAX];
    int         p_tgt [PMAX];
    int         p_len;
    int         wb_at [PMAX];
    bit         st_v  [4];
    int         st_id [4];
    int         pc;

    task automatic clear_prog();
        for (int i = 0; i < PMAX; i++) begin
            p_op[i] = 6'h00; p_rs[i] = '0; p_rt[i] = '0; p_tk[i] = 0; p_tgt[i] = 0; wb_at[i] = -1;
        end
        for (int s = 0; s < 4; s++) begin st_v[s] = 0; st_id[s] = 0; end
        pc = 0; p_len = 0;
    endtask

    task automatic put(input logic [5:0] op, input logic [4:0] rs, input logic [4:0] rt,
                       input bit tk, input int tgt);
        p_op[p_len] = op; p_rs[p_len] = rs; p_rt[p_len] = rt;
        p_tk[p_len] = tk; p_tgt[p_len] = tgt; p_len++;
    endtask

    // Steps the model; stage 0 IF/ID, 1 ID/EX, 2 EX/MEM, 3 MEM/WB
    task automatic run_prog(input int ncyc);
        for (int step = 1; step <= ncyc; step++) begin
            bit nv [4]; int nid [4];
            @(posedge clk); #2;
            id_opcode    = st_v[0] ? p_op[st_id[0]] : 6'h00;
            id_rs        = st_v[0] ? p_rs[st_id[0]] : 5'd0;
            id_rt        = st_v[0] ? p_rt[st_id[0]] : 5'd0;
            ex_is_load   = st_v[1] && (p_op[st_id[1]] == 6'h23);
            ex_load_dst  = st_v[1] ? p_rt[st_id[1]] : 5'd0;
            mem_br_taken = st_v[2] && (p_op[st_id[2]] == 6'h04) && p_tk[st_id[2]];
            mem_jump     = st_v[2] && (p_op[st_id[2]] == 6'h02);
            @(negedge clk);
            if (ifid_clear) begin nv[0] = 0; nid[0] = 0; end
            else if (ifid_hold) begin nv[0] = st_v[0]; nid[0] = st_id[0]; end
            else begin nv[0] = (pc < p_len); nid[0] = pc; end
            if (idex_clear) begin nv[1] = 0; nid[1] = 0; end
            else begin nv[1] = st_v[0]; nid[1] = st_id[0]; end
            if (exmem_clear) begin nv[2] = 0; nid[2] = 0; end
            else begin nv[2] = st_v[1]; nid[2] = st_id[1]; end
            nv[3] = st_v[2]; nid[3] = st_id[2];
            if (pc_redirect) pc = p_tgt[st_id[2]];
            else if (!pc_hold) pc = pc + 1;
            for (int s = 0; s < 4; s++) begin st_v[s] = nv[s]; st_id[s] = nid[s]; end
            if (st_v[3]) wb_at[st_id[3]] = step;
        end
    endtask

    initial begin
        // R8: reset forces all controls low even with hazards present
        drive(6'h00, 5'd5, 5'd6, 1'b1, 5'd5, 1'b0, 1'b0, E_NONE, "R8 reset quiet stall");
        drive(6'h00, 5'd1, 5'd2, 1'b0, 5'd0, 1'b1, 1'b0, E_NONE, "R8 reset quiet flush");
        @(posedge clk); #2; rst_n = 1'b1;

        drive(6'h00, 5'd1, 5'd2, 1'b0, 5'd0, 1'b0, 1'b0, E_NONE,  "R5 idle");
        drive(6'h00, 5'd7, 5'd2, 1'b1, 5'd7, 1'b0, 1'b0, E_STALL, "R1 R2 rs match rtype");
        drive(6'h08, 5'd9, 5'd3, 1'b1, 5'd9, 1'b0, 1'b0, E_STALL, "R2 rs match immediate op");
        drive(6'h02, 5'd9, 5'd9, 1'b1, 5'd9, 1'b0, 1'b0, E_NONE,  "R2 jump reads no register");
        drive(6'h00, 5'd1, 5'd4, 1'b1, 5'd4, 1'b0, 1'b0, E_STALL, "R3 rt match rtype");
        drive(6'h2B, 5'd1, 5'd4, 1'b1, 5'd4, 1'b0, 1'b0, E_STALL, "R3 rt match store");
        drive(6'h04, 5'd1, 5'd4, 1'b1, 5'd4, 1'b0, 1'b0, E_STALL, "R3 rt match beq");
        drive(6'h23, 5'd1, 5'd4, 1'b1, 5'd4, 1'b0, 1'b0, E_NONE,  "R3 rt ignored for load");
        drive(6'h08, 5'd1, 5'd4, 1'b1, 5'd4, 1'b0, 1'b0, E_NONE,  "R3 rt ignored for immediate");
        drive(6'h00, 5'd0, 5'd0, 1'b1, 5'd0, 1'b0, 1'b0, E_NONE,  "R4 load to r0");
        drive(6'h00, 5'd3, 5'd4, 1'b1, 5'd5, 1'b0, 1'b0, E_NONE,  "R5 load no match");
        drive(6'h00, 5'd5, 5'd5, 1'b0, 5'd5, 1'b0, 1'b0, E_NONE,  "R5 match but not load");
        drive(6'h00, 5'd1, 5'd2, 1'b0, 5'd0, 1'b1, 1'b0, E_FLUSH, "R6 taken branch");
        drive(6'h00, 5'd1, 5'd2, 1'b0, 5'd0, 1'b0, 1'b1, E_FLUSH, "R6 jump");
        drive(6'h00, 5'd6, 5'd2, 1'b1, 5'd6, 1'b1, 1'b0, E_FLUSH, "R7 flush beats stall");
        drive(6'h2B, 5'd1, 5'd6, 1'b1, 5'd6, 1'b0, 1'b1, E_FLUSH, "R7 jump beats stall");
        @(posedge clk); @(negedge clk); @(negedge clk);
        check(sb_q.size() == 0, "R5 scoreboard drained", sb_q.size(), 0);

        // R11: independent stream retires one per cycle
        clear_prog();
        for (int i = 0; i < 5; i++) put(6'h00, 5'(i + 1), 5'(i + 10), 0, 0);
        run_prog(12);
        check(wb_at[0] == 4, "R11 first write-back", wb_at[0], 4);
        check(wb_at[4] == 8, "R11 no bubble last", wb_at[4], 8);

        // R9: load then dependent reader costs one cycle
        clear_prog();
        put(6'h23, 5'd0, 5'd5, 0, 0);
        put(6'h00, 5'd5, 5'd6, 0, 0);
        put(6'h00, 5'd1, 5'd2, 0, 0);
        run_prog(12);
        check(wb_at[0] == 4, "R9 load write-back", wb_at[0], 4);
        check(wb_at[1] == 6, "R9 dependent delayed one", wb_at[1], 6);
        check(wb_at[2] == 7, "R9 follower delayed one", wb_at[2], 7);

        // R11: load followed by immediate op writing the same rt: no bubble
        clear_prog();
        put(6'h23, 5'd0, 5'd5, 0, 0);
        put(6'h08, 5'd1, 5'd5, 0, 0);
        run_prog(10);
        check(wb_at[1] == 5, "R11 no false bubble", wb_at[1], 5);

        // R10: taken branch at index 1 to index 5
        clear_prog();
        put(6'h00, 5'd1, 5'd2, 0, 0);
        put(6'h04, 5'd2, 5'd3, 1, 5);
        put(6'h00, 5'd2, 5'd3, 0, 0);
        put(6'h00, 5'd2, 5'd3, 0, 0);
        put(6'h00, 5'd1, 5'd2, 0, 0);
        put(6'h00, 5'd4, 5'd1, 0, 0);
        run_prog(16);
        check(wb_at[1] == 5, "R10 branch write-back", wb_at[1], 5);
        check(wb_at[5] == 9, "R10 target three-cycle penalty", wb_at[5], 9);
        check(wb_at[2] == -1, "R10 shadow 1 flushed", wb_at[2], -1);
        check(wb_at[3] == -1, "R10 shadow 2 flushed", wb_at[3], -1);
        check(wb_at[4] == -1, "R10 shadow 3 flushed", wb_at[4], -1);

        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        #(TCK * 200000);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule